// File: doc/BRIEF.md
# Plug-and-Play Card Control State Machine

This block is the card-side control logic for an auto-configurable expansion card on a legacy 8-bit I/O bus. Software writes a register index to a fixed address port at I/O 0x279. It then writes that register's data to a fixed data port at I/O 0xA79, or reads it back through a read port that software can move. The block tracks which phase of the configuration protocol the card is in: waiting for the unlock key, sleeping, isolating, or being configured. It holds the card select number and the selected logical device, and it carries out the global control commands.

Recognising the unlock key sequence is done outside the block, which sees it only as a one-cycle `key_match` pulse. The resource byte stream is also kept outside. The block gives it a data byte and a ready flag, and the block sends back a pointer-reset pulse. Each logical device's resources are kept outside too, and they receive a one-cycle reset pulse from the block.

Top module: `pnp_card_ctrl`

## Requirements
- R1: After reset, `card_state` is 0 (waiting for key; encoding 0 wait-for-key, 1 sleep, 2 isolation, 3 config), `csn`, `sel_ldev`, the register index and the read-port location are 0, and the `ldev_rst` and `res_ptr_rst` pulses are low.
- R2: A `key_match` pulse in wait-for-key moves the card to sleep on the next clock. In any other state the pulse has no effect.
- R3: In wait-for-key, every write to the data port (I/O 0xA79) is ignored. The state stays 0 and no pulse is produced.
- R4: A data-port write to index 0x00 in any state other than wait-for-key stores the data byte as the read-port location. The port then answers at I/O address {6'b0, data[7:0], 2'b00}.
- R5: A data-port write to index 0x03 whose data equals `csn` gives a one-cycle `res_ptr_rst` pulse. If the card is in sleep, it moves to isolation when the data is 0 and to config otherwise. A write with data that does not match changes nothing.
- R6: Writing index 0x02 with bit 1 set returns the card to wait-for-key and keeps `csn`.
- R7: Writing index 0x02 with bit 0 set gives a single-cycle `ldev_rst` pulse. The pulse clears by itself, and the state, `csn` and `sel_ldev` are kept.
- R8: Writing index 0x02 with bit 2 set clears `csn` to 0 without a state change.
- R9: Index 0x06 holds `csn`. It can be written in isolation or config, writes to it in sleep are ignored, and it can be read back through the read port.
- R10: Index 0x07 sets `sel_ldev`. It can be written only in config, a value of NUM_LDEV or more is ignored, and it reads back zero-extended.
- R11: A read of index 0x05 returns {7'b0, res_ready}. A read of index 0x04 returns `res_data`.
- R12: `rd_oe` is high only while `io_rd` is high, the address equals the read-port location, and the card is in isolation or config. Otherwise `rd_data` is 0. A read of an index with no readable content, such as 0x00, returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 16 | I/O cycle address |
| io_wr | input | 1 | I/O write strobe, one cycle |
| io_rd | input | 1 | I/O read strobe |
| io_wdata | input | 8 | I/O write data |
| key_match | input | 1 | Unlock key recognised (pulse) |
| res_ready | input | 1 | Next resource byte is available |
| res_data | input | 8 | Current resource byte |
| rd_oe | output | 1 | Read data is being driven onto the bus |
| rd_data | output | 8 | Read data |
| card_state | output | 2 | Protocol state |
| csn | output | 8 | Card select number |
| sel_ldev | output | LDN_W (2) | Selected logical device |
| ldev_rst | output | 1 | Logical device configuration reset pulse |
| res_ptr_rst | output | 1 | Resource byte pointer reset pulse |

## Verification
The wake command is tried with a select number that does not match, with a zero value that matches, and with a nonzero value that matches. These three cases tell the ignored path apart from the move to isolation and the move to config. The control register is written with each command bit on its own, so that the device reset, the select-number clear and the return to wait-for-key can each be seen separately. Reads are made at the programmed port, at a neighbouring address and in states where the port is closed. This separates address decoding from gating by state. Writes in wait-for-key, in sleep and in isolation show which registers are locked in each state.

// File: rtl/pnp_pkg.sv
package pnp_pkg;

  localparam int IO_AW = 16;

  typedef enum logic [1:0] {
    ST_WFK   = 2'd0,
    ST_SLEEP = 2'd1,
    ST_ISO   = 2'd2,
    ST_CFG   = 2'd3
  } card_st_t;

  localparam logic [7:0] IDX_RDPORT = 8'h00;
  localparam logic [7:0] IDX_CFGCTL = 8'h02;
  localparam logic [7:0] IDX_WAKE   = 8'h03;
  localparam logic [7:0] IDX_RESDAT = 8'h04;
  localparam logic [7:0] IDX_STATUS = 8'h05;
  localparam logic [7:0] IDX_CSN    = 8'h06;
  localparam logic [7:0] IDX_LDN    = 8'h07;

  // Control register command bits
  localparam int CC_LDRST = 0;
  localparam int CC_WFK   = 1;
  localparam int CC_CSNCLR = 2;

  // Read-port location byte to full I/O address
  function automatic logic [IO_AW-1:0] rd_port_to_io(input logic [7:0] loc);
    return {6'b0, loc, 2'b00};
  endfunction

  // Next state on a matching wake write
  function automatic card_st_t wake_target(input logic [7:0] data);
    return (data == 8'd0) ? ST_ISO : ST_CFG;
  endfunction

endpackage

// File: rtl/pnp_port_decode.sv
module pnp_port_decode
  import pnp_pkg::*;
#(
  parameter logic [IO_AW-1:0] ADDR_PORT  = 16'h0279,
  parameter logic [IO_AW-1:0] WDATA_PORT = 16'h0A79
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IO_AW-1:0] io_addr,
  input  logic             io_wr,
  input  logic [7:0]       io_wdata,
  output logic             wr_addr_port,
  output logic             wr_data_port,
  output logic [7:0]       reg_idx
);

  assign wr_addr_port = io_wr && (io_addr == ADDR_PORT);
  assign wr_data_port = io_wr && (io_addr == WDATA_PORT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_idx <= 8'd0;
    end else if (wr_addr_port) begin
      reg_idx <= io_wdata;
    end
  end

endmodule

// File: rtl/pnp_card_fsm.sv
module pnp_card_fsm
  import pnp_pkg::*;
#(
  parameter int NUM_LDEV = 4,
  localparam int LDN_W = (NUM_LDEV > 1) ? $clog2(NUM_LDEV) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             key_match,
  input  logic             wr_data_port,
  input  logic [7:0]       reg_idx,
  input  logic [7:0]       wdata,
  output card_st_t         state,
  output logic [7:0]       csn,
  output logic [LDN_W-1:0] ldn,
  output logic [7:0]       rd_port,
  output logic             ldev_rst,
  output logic             res_ptr_rst,
  output logic             wake_hit
);

  logic live_wr;
  logic cc_wr;
  logic csn_wr;
  logic ldn_wr;

  assign live_wr  = wr_data_port && (state != ST_WFK);
  assign cc_wr    = live_wr && (reg_idx == IDX_CFGCTL);
  assign wake_hit = live_wr && (reg_idx == IDX_WAKE) && (wdata == csn);
  assign csn_wr   = live_wr && (reg_idx == IDX_CSN) &&
                    ((state == ST_ISO) || (state == ST_CFG));
  assign ldn_wr   = live_wr && (reg_idx == IDX_LDN) && (state == ST_CFG) &&
                    ({24'd0, wdata} < 32'(NUM_LDEV));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_WFK;
      csn         <= 8'd0;
      rd_port     <= 8'd0;
      ldev_rst    <= 1'b0;
      res_ptr_rst <= 1'b0;
    end else begin
      ldev_rst    <= 1'b0;
      res_ptr_rst <= 1'b0;
      if (state == ST_WFK) begin
        if (key_match) state <= ST_SLEEP;
      end
      if (live_wr && (reg_idx == IDX_RDPORT)) rd_port <= wdata;
      if (cc_wr) begin
        if (wdata[CC_LDRST])  ldev_rst <= 1'b1;
        if (wdata[CC_CSNCLR]) csn <= 8'd0;
        if (wdata[CC_WFK])    state <= ST_WFK;
      end
      if (wake_hit) begin
        res_ptr_rst <= 1'b1;
        if (state == ST_SLEEP) state <= wake_target(wdata);
      end
      if (csn_wr) csn <= wdata;
    end
  end

  generate
    if (NUM_LDEV > 1) begin : g_multi
      always_ff @(posedge clk) begin
        if (!rst_n) ldn <= '0;
        else if (ldn_wr) ldn <= wdata[LDN_W-1:0];
      end
    end else begin : g_single
      logic unused_ldn_wr;
      assign unused_ldn_wr = ldn_wr;
      assign ldn = '0;
    end
  endgenerate

endmodule

// File: rtl/pnp_read_mux.sv
module pnp_read_mux
  import pnp_pkg::*;
#(
  parameter int LDN_W = 2
) (
  input  logic             io_rd,
  input  logic [IO_AW-1:0] io_addr,
  input  card_st_t         state,
  input  logic [7:0]       rd_port,
  input  logic [7:0]       reg_idx,
  input  logic [7:0]       csn,
  input  logic [LDN_W-1:0] ldn,
  input  logic             res_ready,
  input  logic [7:0]       res_data,
  output logic             rd_hit,
  output logic [7:0]       rd_data
);

  logic       port_open;
  logic [7:0] sel_byte;

  assign port_open = (state == ST_ISO) || (state == ST_CFG);
  assign rd_hit    = io_rd && port_open && (io_addr == rd_port_to_io(rd_port));

  always_comb begin
    case (reg_idx)
      IDX_RESDAT: sel_byte = res_data;
      IDX_STATUS: sel_byte = {7'd0, res_ready};
      IDX_CSN:    sel_byte = csn;
      IDX_LDN:    sel_byte = 8'(ldn);
      default:    sel_byte = 8'd0;
    endcase
  end

  assign rd_data = rd_hit ? sel_byte : 8'd0;

endmodule

// File: rtl/pnp_card_ctrl.sv
module pnp_card_ctrl
  import pnp_pkg::*;
#(
  parameter int NUM_LDEV = 4,
  parameter logic [15:0] ADDR_PORT  = 16'h0279,
  parameter logic [15:0] WDATA_PORT = 16'h0A79,
  localparam int LDN_W = (NUM_LDEV > 1) ? $clog2(NUM_LDEV) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [15:0]      io_addr,
  input  logic             io_wr,
  input  logic             io_rd,
  input  logic [7:0]       io_wdata,
  input  logic             key_match,
  input  logic             res_ready,
  input  logic [7:0]       res_data,
  output logic             rd_oe,
  output logic [7:0]       rd_data,
  output logic [1:0]       card_state,
  output logic [7:0]       csn,
  output logic [LDN_W-1:0] sel_ldev,
  output logic             ldev_rst,
  output logic             res_ptr_rst
);

  logic       wr_addr_port;
  logic       wr_data_port;
  logic       wake_hit;
  logic [7:0] reg_idx;
  logic [7:0] rd_port;
  card_st_t   state;

  pnp_port_decode #(
    .ADDR_PORT (ADDR_PORT),
    .WDATA_PORT(WDATA_PORT)
  ) u_dec (
    .clk         (clk),
    .rst_n       (rst_n),
    .io_addr     (io_addr),
    .io_wr       (io_wr),
    .io_wdata    (io_wdata),
    .wr_addr_port(wr_addr_port),
    .wr_data_port(wr_data_port),
    .reg_idx     (reg_idx)
  );

  pnp_card_fsm #(
    .NUM_LDEV(NUM_LDEV)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .key_match   (key_match),
    .wr_data_port(wr_data_port),
    .reg_idx     (reg_idx),
    .wdata       (io_wdata),
    .state       (state),
    .csn         (csn),
    .ldn         (sel_ldev),
    .rd_port     (rd_port),
    .ldev_rst    (ldev_rst),
    .res_ptr_rst (res_ptr_rst),
    .wake_hit    (wake_hit)
  );

  pnp_read_mux #(
    .LDN_W(LDN_W)
  ) u_rd (
    .io_rd    (io_rd),
    .io_addr  (io_addr),
    .state    (state),
    .rd_port  (rd_port),
    .reg_idx  (reg_idx),
    .csn      (csn),
    .ldn      (sel_ldev),
    .res_ready(res_ready),
    .res_data (res_data),
    .rd_hit   (rd_oe),
    .rd_data  (rd_data)
  );

  assign card_state = state;

endmodule

// File: rtl/pnp_card_ctrl_chk.sv
module pnp_card_ctrl_chk
  import pnp_pkg::*;
#(
  parameter int NUM_LDEV = 4,
  localparam int LDN_W = (NUM_LDEV > 1) ? $clog2(NUM_LDEV) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       state,
  input logic             key_match,
  input logic             wr_data_port,
  input logic             wake_hit,
  input logic [7:0]       csn,
  input logic [LDN_W-1:0] sel_ldev,
  input logic             rd_oe,
  input logic             res_ptr_rst
);

  assert_key_sleep_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WFK && key_match) |=> (state == ST_SLEEP));

  assert_wfk_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WFK && !key_match) |=> (state == ST_WFK && !res_ptr_rst));

  assert_wake_iso_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SLEEP) |=> (state != ST_ISO || csn == 8'd0));

  assert_wake_cfg_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SLEEP) |=> (state != ST_CFG || csn != 8'd0));

  assert_wake_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wake_hit |=> res_ptr_rst);

  assert_csn_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_data_port |=> $stable(csn));

  assert_ldn_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ({{(32-LDN_W){1'b0}}, sel_ldev} < 32'(NUM_LDEV)));

  assert_oe_gate_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rd_oe |-> (state == ST_ISO || state == ST_CFG));

endmodule

bind pnp_card_ctrl pnp_card_ctrl_chk #(.NUM_LDEV(NUM_LDEV)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .state       (card_state),
  .key_match   (key_match),
  .wr_data_port(wr_data_port),
  .wake_hit    (wake_hit),
  .csn         (csn),
  .sel_ldev    (sel_ldev),
  .rd_oe       (rd_oe),
  .res_ptr_rst (res_ptr_rst)
);

// File: tb/pnp_card_ctrl_tb.sv
module pnp_card_ctrl_tb;

  localparam logic [15:0] AP = 16'h0279;
  localparam logic [15:0] DP = 16'h0A79;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] io_addr = '0;
  logic        io_wr = 1'b0;
  logic        io_rd = 1'b0;
  logic [7:0]  io_wdata = '0;
  logic        key_match = 1'b0;
  logic        res_ready = 1'b0;
  logic [7:0]  res_data = '0;
  logic        rd_oe;
  logic [7:0]  rd_data;
  logic [1:0]  card_state;
  logic [7:0]  csn;
  logic [1:0]  sel_ldev;
  logic        ldev_rst;
  logic        res_ptr_rst;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  logic [7:0] rv;
  logic       ro;

  always #2.5 clk = ~clk;

  pnp_card_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .key_match(key_match), .res_ready(res_ready),
    .res_data(res_data), .rd_oe(rd_oe), .rd_data(rd_data),
    .card_state(card_state), .csn(csn), .sel_ldev(sel_ldev),
    .ldev_rst(ldev_rst), .res_ptr_rst(res_ptr_rst)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    #1;
    ro = rd_oe; rv = rd_data;
    @(negedge clk);
    io_rd = 1'b0;
  endtask

  task automatic key();
    @(negedge clk); key_match = 1'b1;
    @(negedge clk); key_match = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 state", card_state, 0);
    check("R1 csn", csn, 0);
    check("R1 ldn", sel_ldev, 0);
    check("R1 pulses", {ldev_rst, res_ptr_rst}, 0);
    rd(16'h0000);
    check("R12 closed in wait-for-key", ro, 0);
    check("R12 data zero", rv, 0);
  endtask

  task automatic t_wfk_ignore();
    wr(AP, 8'h03); wr(DP, 8'h00);
    check("R3 wake ignored state", card_state, 0);
    check("R3 no pointer pulse", res_ptr_rst, 0);
  endtask

  task automatic t_key();
    key();
    check("R2 key to sleep", card_state, 1);
    key();
    check("R2 key ignored in sleep", card_state, 1);
  endtask

  task automatic t_wake_iso();
    wr(AP, 8'h00); wr(DP, 8'h80);
    rd(16'h0200);
    check("R12 closed in sleep", ro, 0);
    wr(AP, 8'h03); wr(DP, 8'h05);
    check("R5 mismatch keeps sleep", card_state, 1);
    check("R5 mismatch no pulse", res_ptr_rst, 0);
    wr(DP, 8'h00);
    check("R5 zero wake to isolation", card_state, 2);
    check("R5 pointer pulse", res_ptr_rst, 1);
    @(negedge clk);
    check("R5 pulse clears", res_ptr_rst, 0);
    rd(16'h0200);
    check("R4 port at 0x200 answers", ro, 1);
    check("R12 wake index reads zero", rv, 0);
    rd(16'h0204);
    check("R12 neighbour address closed", ro, 0);
  endtask

  task automatic t_iso_regs();
    wr(AP, 8'h07); wr(DP, 8'h01);
    check("R10 ldn locked in isolation", sel_ldev, 0);
    wr(AP, 8'h06); wr(DP, 8'h05);
    check("R9 csn write in isolation", csn, 5);
    check("R9 state kept", card_state, 2);
    wr(AP, 8'h02); wr(DP, 8'h02);
    check("R6 back to wait-for-key", card_state, 0);
    check("R6 csn kept", csn, 5);
  endtask

  task automatic t_to_config();
    key();
    wr(AP, 8'h06); wr(DP, 8'h09);
    check("R9 csn locked in sleep", csn, 5);
    wr(AP, 8'h03); wr(DP, 8'h05);
    check("R5 nonzero wake to config", card_state, 3);
    wr(AP, 8'h06); rd(16'h0200);
    check("R9 csn readback", rv, 8'h05);
  endtask

  task automatic t_ldn_status();
    wr(AP, 8'h07); wr(DP, 8'h02);
    check("R10 ldn written", sel_ldev, 2);
    rd(16'h0200);
    check("R10 ldn readback", rv, 8'h02);
    wr(DP, 8'h04);
    check("R10 out-of-range ignored", sel_ldev, 2);
    res_ready = 1'b1; res_data = 8'hA5;
    wr(AP, 8'h05); rd(16'h0200);
    check("R11 status ready", rv, 8'h01);
    res_ready = 1'b0; rd(16'h0200);
    check("R11 status not ready", rv, 8'h00);
    wr(AP, 8'h04); rd(16'h0200);
    check("R11 resource byte", rv, 8'hA5);
  endtask

  task automatic t_move_port();
    wr(AP, 8'h00); wr(DP, 8'h3F);
    rd(16'h0200);
    check("R4 old port closed", ro, 0);
    rd(16'h00FC);
    check("R4 new port 0x0FC", ro, 1);
    check("R12 index 0 reads zero", rv, 0);
  endtask

  task automatic t_cfgctl();
    wr(AP, 8'h02); wr(DP, 8'h01);
    check("R7 device reset pulse", ldev_rst, 1);
    check("R7 state kept", card_state, 3);
    check("R7 csn kept", csn, 5);
    check("R7 ldn kept", sel_ldev, 2);
    @(negedge clk);
    check("R7 pulse self-clears", ldev_rst, 0);
    wr(DP, 8'h04);
    check("R8 csn cleared", csn, 0);
    check("R8 state kept", card_state, 3);
    wr(DP, 8'h02);
    check("R6 to wait-for-key", card_state, 0);
    rd(16'h00FC);
    check("R12 closed after return", ro, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_wfk_ignore();
    t_key();
    t_wake_iso();
    t_iso_regs();
    t_to_config();
    t_ldn_status();
    t_move_port();
    t_cfgctl();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule